// File: doc/BRIEF.md
# Slave Address Coincidence and Wake-Up Gate

This block sits beside a serial bus slave's receive shifter. Software programs an own-address value. Each time the bus front end marks a received byte as an address, the block compares that byte with the programmed value. The comparison can optionally ignore the least significant bit, which makes two neighbouring addresses answer as one. A registered coincidence flag shows the result of the most recent address compare. The block also keeps a release-detect flag: a bus-release event sets it, and an address that does not match clears it.

The block also shapes the interrupt request. With wake-up enabled, only an address that matches raises the request, so a sleeping slave is woken only when it is the one being called. An interrupt-source select bit overrides wake-up and makes the request follow bus-release events instead. In three-wire mode the compare has no use, so the block keeps the coincidence flag and the interrupt quiet. Serial shifting and protocol decoding take place outside this block.

Top module: `slave_addr_match`

## Requirements
- R1: After reset, matchFlag, releaseFlag and irqPulse are all 0.
- R2: While addrWrEn is high on a clock edge, addrWrData is stored as the own address. Every address compare at a later edge uses the stored value.
- R3: When maskLsb=0, an address event is addrStrobe=1 with busMode=1 on a clock edge. On an address event, matchFlag is set to 1 from that edge onward if rxByte equals the stored address in all 8 bits, and to 0 otherwise.
- R4: When maskLsb=1, the compare uses only bits 7..1. Bit 0 of rxByte and bit 0 of the stored address are ignored.
- R5: In bus mode, matchFlag changes only on an address event. Changes on rxByte with no strobe have no effect.
- R6: In bus mode, releaseStrobe=1 sets releaseFlag to 1. An address event that does not match clears it to 0. A matching address event leaves it unchanged.
- R7: If a release strobe and a mismatching address event fall on the same edge, releaseFlag ends at 1.
- R8: irqPulse is high for exactly the one cycle that follows the edge on which its triggering event was sampled.
- R9: With busMode=1, wakeEn=1 and irqSrcSel=0, irqPulse fires only for a matching address event. Mismatching addresses and release strobes do not fire it.
- R10: With busMode=1 and irqSrcSel=1, irqPulse fires on a release strobe and not on an address event, whatever the value of wakeEn.
- R11: With busMode=1, wakeEn=0 and irqSrcSel=0, irqPulse fires on every address event, whether it matches or not, and not on a release strobe.
- R12: With busMode=0 (three-wire mode), matchFlag is 0 from the next edge onward, irqPulse stays 0, and addrStrobe and releaseStrobe leave releaseFlag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addrWrEn | input | 1 | Write strobe for the own-address register |
| addrWrData | input | 8 | Value written to the own address |
| rxByte | input | 8 | Received byte from the shifter |
| addrStrobe | input | 1 | Marks rxByte as an address byte |
| releaseStrobe | input | 1 | Bus-release detected |
| busMode | input | 1 | 1 = addressed bus mode, 0 = three-wire mode |
| maskLsb | input | 1 | Ignore bit 0 in the compare |
| wakeEn | input | 1 | Interrupt only on address match |
| irqSrcSel | input | 1 | 1 = interrupt on bus release |
| matchFlag | output | 1 | Result of the last address compare |
| releaseFlag | output | 1 | Release-detect status |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The compare is tried with an exact match, a byte that differs only in bit 0, a byte that differs in a high bit, and a byte that differs from the stored address only in bit 0. Running these with the mask both off and on shows whether the mask touches bit 0 alone. Address and release strobes are applied under each combination of wake-up enable and source select. This shows which event type each setting lets through to the interrupt. Simultaneous release and mismatch events, rxByte changes with no strobe, and a switch to three-wire mode show the priority, hold and quiet rules.

// File: rtl/slave_addr_match_pkg.sv
package slave_addr_match_pkg;
  typedef struct packed {
    logic loadAddr;
    logic capture;
    logic clearMatch;
    logic setRel;
    logic clrRel;
    logic fireIrq;
  } matchStrobes_t;

  typedef enum logic [1:0] {
    IRQ_ON_ADDR    = 2'd0,
    IRQ_ON_WAKE    = 2'd1,
    IRQ_ON_RELEASE = 2'd2
  } irqSource_e;
endpackage

// File: rtl/slave_addr_match_dp.sv
module slave_addr_match_dp
  import slave_addr_match_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  matchStrobes_t     strobes,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic [ADDR_W-1:0] rxByte,
  input  logic              maskLsb,
  output logic              hit,
  output logic              matchFlag,
  output logic              releaseFlag,
  output logic              irqPulse
);
  localparam int UPPER_W = ADDR_W - 1;

  logic [ADDR_W-1:0] ownAddr;
  logic upperEq;
  logic lsbEq;

  assign upperEq = (rxByte[ADDR_W-1:1] == ownAddr[ADDR_W-1:1]);
  assign lsbEq   = (rxByte[0] == ownAddr[0]);
  assign hit     = upperEq && (maskLsb || lsbEq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ownAddr     <= '0;
      matchFlag   <= 1'b0;
      releaseFlag <= 1'b0;
      irqPulse    <= 1'b0;
    end else begin
      if (strobes.loadAddr) ownAddr <= addrWrData;
      if (strobes.clearMatch)   matchFlag <= 1'b0;
      else if (strobes.capture) matchFlag <= hit;
      if (strobes.setRel)      releaseFlag <= 1'b1;
      else if (strobes.clrRel) releaseFlag <= 1'b0;
      irqPulse <= strobes.fireIrq;
    end
  end

  logic [UPPER_W-1:0] unusedWidth;
  assign unusedWidth = '0;
endmodule

// File: rtl/slave_addr_match_ctrl.sv
module slave_addr_match_ctrl
  import slave_addr_match_pkg::*;
(
  input  logic          addrWrEn,
  input  logic          addrStrobe,
  input  logic          releaseStrobe,
  input  logic          busMode,
  input  logic          wakeEn,
  input  logic          irqSrcSel,
  input  logic          hit,
  output matchStrobes_t strobes
);
  irqSource_e irqSource;
  logic addrEvent;
  logic relEvent;

  assign addrEvent = busMode && addrStrobe;
  assign relEvent  = busMode && releaseStrobe;

  always_comb begin
    if (irqSrcSel)   irqSource = IRQ_ON_RELEASE;
    else if (wakeEn) irqSource = IRQ_ON_WAKE;
    else             irqSource = IRQ_ON_ADDR;
  end

  always_comb begin
    strobes.loadAddr   = addrWrEn;
    strobes.capture    = addrEvent;
    strobes.clearMatch = !busMode;
    strobes.setRel     = relEvent;
    strobes.clrRel     = addrEvent && !hit && !relEvent;
    case (irqSource)
      IRQ_ON_RELEASE: strobes.fireIrq = relEvent;
      IRQ_ON_WAKE:    strobes.fireIrq = addrEvent && hit;
      default:        strobes.fireIrq = addrEvent;
    endcase
  end
endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match
  import slave_addr_match_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic [ADDR_W-1:0] rxByte,
  input  logic              addrStrobe,
  input  logic              releaseStrobe,
  input  logic              busMode,
  input  logic              maskLsb,
  input  logic              wakeEn,
  input  logic              irqSrcSel,
  output logic              matchFlag,
  output logic              releaseFlag,
  output logic              irqPulse
);
  matchStrobes_t strobes;
  logic hit;

  slave_addr_match_ctrl u_ctrl (
    .addrWrEn      (addrWrEn),
    .addrStrobe    (addrStrobe),
    .releaseStrobe (releaseStrobe),
    .busMode       (busMode),
    .wakeEn        (wakeEn),
    .irqSrcSel     (irqSrcSel),
    .hit           (hit),
    .strobes       (strobes)
  );

  slave_addr_match_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .addrWrData  (addrWrData),
    .rxByte      (rxByte),
    .maskLsb     (maskLsb),
    .hit         (hit),
    .matchFlag   (matchFlag),
    .releaseFlag (releaseFlag),
    .irqPulse    (irqPulse)
  );
endmodule

// File: rtl/slave_addr_match_checker.sv
module slave_addr_match_checker (
  input logic clk,
  input logic rst_n,
  input logic addrStrobe,
  input logic releaseStrobe,
  input logic busMode,
  input logic wakeEn,
  input logic irqSrcSel,
  input logic matchFlag,
  input logic releaseFlag,
  input logic irqPulse
);
  // R5: the flag holds unless an address event was sampled in bus mode
  p_match_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busMode && !addrStrobe) |=> $stable(matchFlag));

  // R6: a release strobe in bus mode sets the release flag
  p_release_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busMode && releaseStrobe) |=> releaseFlag);

  // R8: the interrupt follows only a sampled strobe
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPulse) |-> $past(addrStrobe || releaseStrobe));

  // R9: under wake-up gating, an interrupt implies a match
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busMode && wakeEn && !irqSrcSel) |=> (!irqPulse || matchFlag));

  // R10: with source select, interrupts follow release strobes only
  p_src_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqSrcSel && !releaseStrobe) |=> !irqPulse);

  // R12: three-wire mode keeps the flag and the interrupt low
  p_three_wire_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busMode |=> (!matchFlag && !irqPulse));

  // R12: three-wire mode leaves the release flag untouched
  p_three_wire_rel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busMode |=> $stable(releaseFlag));
endmodule

bind slave_addr_match slave_addr_match_checker u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .addrStrobe    (addrStrobe),
  .releaseStrobe (releaseStrobe),
  .busMode       (busMode),
  .wakeEn        (wakeEn),
  .irqSrcSel     (irqSrcSel),
  .matchFlag     (matchFlag),
  .releaseFlag   (releaseFlag),
  .irqPulse      (irqPulse)
);

// File: tb/tb_slave_addr_match.sv
`timescale 1ns/1ps
module tb_slave_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addrWrEn = 1'b0;
  logic [7:0] addrWrData = '0;
  logic [7:0] rxByte = '0;
  logic addrStrobe = 1'b0;
  logic releaseStrobe = 1'b0;
  logic busMode = 1'b1;
  logic maskLsb = 1'b0;
  logic wakeEn = 1'b0;
  logic irqSrcSel = 1'b0;
  logic matchFlag, releaseFlag, irqPulse;
  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  slave_addr_match dut (
    .clk(clk), .rst_n(rst_n), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .rxByte(rxByte), .addrStrobe(addrStrobe), .releaseStrobe(releaseStrobe),
    .busMode(busMode), .maskLsb(maskLsb), .wakeEn(wakeEn), .irqSrcSel(irqSrcSel),
    .matchFlag(matchFlag), .releaseFlag(releaseFlag), .irqPulse(irqPulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeAddr(input logic [7:0] a);
    @(negedge clk); addrWrEn = 1'b1; addrWrData = a;
    @(negedge clk); addrWrEn = 1'b0;
  endtask

  // Drive one cycle of strobes; outputs are sampled 1 ns after the edge.
  task automatic strobe(input logic a, input logic r, input logic [7:0] b);
    @(negedge clk); addrStrobe = a; releaseStrobe = r; rxByte = b;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk); addrStrobe = 1'b0; releaseStrobe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 matchFlag", matchFlag, 1'b0);
    chk("R1 releaseFlag", releaseFlag, 1'b0);
    chk("R1 irqPulse", irqPulse, 1'b0);
  endtask

  task automatic t_full();
    busMode = 1'b1; maskLsb = 1'b0; wakeEn = 1'b0; irqSrcSel = 1'b0;
    writeAddr(8'h5A);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R2/R3 exact match", matchFlag, 1'b1);
    chk("R11 irq on match", irqPulse, 1'b1);
    idle();
    chk("R8 irq one cycle", irqPulse, 1'b0);
    strobe(1'b1, 1'b0, 8'h5B);
    chk("R3 lsb differs", matchFlag, 1'b0);
    chk("R11 irq on mismatch", irqPulse, 1'b1);
    strobe(1'b1, 1'b0, 8'hDA);
    chk("R3 msb differs", matchFlag, 1'b0);
    strobe(1'b0, 1'b0, 8'h5A);
    idle();
    chk("R5 no strobe hold", matchFlag, 1'b0);
    strobe(1'b1, 1'b0, 8'h5A);
    strobe(1'b0, 1'b0, 8'h00);
    idle();
    chk("R5 hold after match", matchFlag, 1'b1);
    writeAddr(8'hC3);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R2 old address rejected", matchFlag, 1'b0);
    strobe(1'b1, 1'b0, 8'hC3);
    chk("R2 new address accepted", matchFlag, 1'b1);
    idle();
  endtask

  task automatic t_mask();
    writeAddr(8'h5A);
    maskLsb = 1'b1;
    strobe(1'b1, 1'b0, 8'h5B);
    chk("R4 lsb ignored", matchFlag, 1'b1);
    strobe(1'b1, 1'b0, 8'h4A);
    chk("R4 upper bit counted", matchFlag, 1'b0);
    writeAddr(8'h5B);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R4 stored lsb ignored", matchFlag, 1'b1);
    maskLsb = 1'b0;
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R3 mask off lsb counted", matchFlag, 1'b0);
    idle();
    writeAddr(8'h5A);
  endtask

  task automatic t_release();
    wakeEn = 1'b0; irqSrcSel = 1'b0;
    strobe(1'b0, 1'b1, 8'h00);
    chk("R6 release sets", releaseFlag, 1'b1);
    chk("R11 no irq on release", irqPulse, 1'b0);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R6 match keeps", releaseFlag, 1'b1);
    strobe(1'b1, 1'b0, 8'h11);
    chk("R6 mismatch clears", releaseFlag, 1'b0);
    strobe(1'b1, 1'b1, 8'h11);
    chk("R7 set wins", releaseFlag, 1'b1);
    idle();
  endtask

  task automatic t_wake();
    wakeEn = 1'b1; irqSrcSel = 1'b0;
    strobe(1'b1, 1'b0, 8'h22);
    chk("R9 mismatch no irq", irqPulse, 1'b0);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R9 match irq", irqPulse, 1'b1);
    strobe(1'b0, 1'b1, 8'h00);
    chk("R9 release no irq", irqPulse, 1'b0);
    idle();
  endtask

  task automatic t_src();
    wakeEn = 1'b1; irqSrcSel = 1'b1;
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R10 match flag set", matchFlag, 1'b1);
    chk("R10 no irq on address", irqPulse, 1'b0);
    strobe(1'b0, 1'b1, 8'h00);
    chk("R10 irq on release", irqPulse, 1'b1);
    idle();
    chk("R8 release irq one cycle", irqPulse, 1'b0);
    wakeEn = 1'b0;
    strobe(1'b0, 1'b1, 8'h00);
    chk("R10 irq wake off", irqPulse, 1'b1);
    idle();
  endtask

  task automatic t_three_wire();
    wakeEn = 1'b0; irqSrcSel = 1'b0;
    strobe(1'b1, 1'b0, 8'h33);
    chk("R6 prep clear release", releaseFlag, 1'b0);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R12 prep match", matchFlag, 1'b1);
    busMode = 1'b0;
    idle();
    chk("R12 match cleared", matchFlag, 1'b0);
    strobe(1'b1, 1'b0, 8'h5A);
    chk("R12 address ignored", matchFlag, 1'b0);
    chk("R12 no irq on address", irqPulse, 1'b0);
    irqSrcSel = 1'b1;
    strobe(1'b0, 1'b1, 8'h00);
    chk("R12 no irq on release", irqPulse, 1'b0);
    chk("R12 release flag kept", releaseFlag, 1'b0);
    idle();
    busMode = 1'b1; irqSrcSel = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_full();
    t_mask();
    t_release();
    t_wake();
    t_src();
    t_three_wire();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checkCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end
endmodule